// File: doc/BRIEF.md
# Serial Bus Word Transmitter Sequencer

This block turns a 16-bit parallel word into one serial bus word of the MIL-STD-1553 kind. Each word takes 20 bit times: a 3-bit-time sync, 16 Manchester II data bits sent MSB first, and an odd parity bit. The line is driven as a pair of complementary legs. A free-running bit clock sets the timing, and that clock is exported. It is derived from the system clock by a divider, with `HALF_CLKS` system clocks per half bit.

The subsystem writes words through two register ranks. The first rank follows the parallel input while it is open and holds its value once closed. A per-byte, active-low load strobe copies each byte into the second rank. The encoder captures the second rank at the moment the send-data window opens. A word is started by pulling the active-low enable low. While the enable stays low at the end of a word, further words follow with no gap. A fail-safe timer stops any message that runs past its bit-time limit (768 by default) and raises a timeout flag. An active-low master reset aborts everything.

Top module: `mbus_word_tx`

## Requirements
- R1: During and after reset, with the enable high, both line legs are low (null), send_data is low and fs_timeout is low.
- R2: A word cycle starts at the first falling edge of bit_clk that sees tx_en_n low. send_data rises at the third falling edge after that start, which is 5 half-bit times after the sync begins. send_data then stays high for exactly 16 bit periods.
- R3: sync_sel is sampled on the rising bit_clk edge that starts the line output of a word. A 0 gives a command sync: 3 half-bits high, then 3 low. A 1 gives a data sync: 3 half-bits low, then 3 high.
- R4: The 16 data bits follow the sync MSB first, one bit cell per bit period. A 1 is sent high then low, and a 0 is sent low then high. Each cell begins on a rising edge of bit_clk.
- R5: A parity cell follows bit 0. It is Manchester coded like a data bit, and it makes the count of ones across the 16 data bits plus parity odd.
- R6: While a word is on the line, tx_neg is always the complement of tx_pos. The two legs are never high together.
- R7: If tx_en_n is low at the rising bit_clk edge inside the last period of a word, the next word's sync begins right after the parity cell, with no gap.
- R8: If tx_en_n is high at that edge, the line returns to null after the parity cell and no further word starts.
- R9: The first rank follows par_in while r1_open is 1 and holds its value while r1_open is 0. Input changes made after closing do not reach the transmitted word.
- R10: load_n bit 0 controls bits 7:0 and load_n bit 1 controls bits 15:8. A 0 copies that byte from the first rank to the second rank, and a 1 leaves that byte of the second rank unchanged.
- R11: When a message reaches FAILSAFE_BITS (768) bit periods, it is cut off at the falling bit_clk edge that ends period 768. fs_timeout then goes high, the line goes null and send_data goes low. No new word starts until tx_en_n returns high, which clears fs_timeout.
- R12: A low on rst_n aborts a word in progress. When reset is released, the outputs are null and nothing resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous master reset |
| tx_en_n | input | 1 | Active-low transmit enable |
| sync_sel | input | 1 | Sync type: 1 selects a data sync, 0 selects a command/status sync |
| par_in | input | DATA_W | Parallel word into the first rank |
| r1_open | input | 1 | 1 makes the first rank follow par_in |
| load_n | input | DATA_W/8 | Per-byte active-low copy from the first rank to the second rank |
| tx_pos | output | 1 | Positive line leg |
| tx_neg | output | 1 | Negative line leg |
| send_data | output | 1 | Window in which the data bits are taken |
| bit_clk | output | 1 | Bit clock; it falls at each bit-period boundary |
| fs_timeout | output | 1 | Fail-safe cutoff flag |

## Verification
The line is checked half-bit by half-bit against a predicted stream. The words cover alternating patterns, all zeros, all ones and a single set LSB, so that parity sense, bit order and cell polarity can each be told apart. Messages mix both sync types. Single words and a three-word run with mid-message reloads distinguish stopping from continuing. A partial byte load separates the two lanes. A constant-word run of 39 words shows exactly where the fail-safe cuts off, and a reset during a word shows that the abort works.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_t;

   typedef enum logic [0:0] {
      SYNC_CMD  = 1'b0,
      SYNC_DATA = 1'b1
   } sync_kind_t;

   // half-bit slots taken by a sync (1.5 bit times each level)
   localparam int SYNC_HALVES = 6;
   localparam int LANE_W      = 8;

   // line level of a sync half slot: command sync starts high
   function automatic logic sync_level(input sync_kind_t kind, input int h);
      logic first_part;
      first_part = (h < SYNC_HALVES / 2);
      return (kind == SYNC_CMD) ? first_part : !first_part;
   endfunction

endpackage

// File: rtl/mbt_bitclk.sv
module mbt_bitclk #(
   parameter int HALF_CLKS = 4
)(
   input  logic clk,
   input  logic rst_n,
   output logic bit_clk,
   output logic fall_next,
   output logic rise_next
);
   localparam int PW = $clog2(2 * HALF_CLKS);
   localparam logic [PW-1:0] PH_LAST = PW'(2 * HALF_CLKS - 1);
   localparam logic [PW-1:0] PH_MID  = PW'(HALF_CLKS - 1);
   localparam logic [PW-1:0] PH_HIGH = PW'(HALF_CLKS);

   logic [PW-1:0] phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= '0;
      else if (phase == PH_LAST)
         phase <= '0;
      else
         phase <= phase + 1'b1;
   end

   // low in the first half of the period, high in the second
   assign bit_clk   = (phase >= PH_HIGH);
   assign fall_next = (phase == PH_LAST);
   assign rise_next = (phase == PH_MID);

endmodule

// File: rtl/mbt_ranks.sv
module mbt_ranks import mbt_pkg::*; #(
   parameter int DATA_W = 16,
   localparam int LANES = DATA_W / LANE_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] par_in,
   input  logic              r1_open,
   input  logic [LANES-1:0]  load_n,
   output logic [DATA_W-1:0] r2_word
);
   logic [LANE_W-1:0] rank1 [LANES];
   logic [LANE_W-1:0] rank2 [LANES];

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rank1[b] <= '0;
         else if (r1_open)
            rank1[b] <= par_in[b*LANE_W +: LANE_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rank2[b] <= '0;
         else if (!load_n[b])
            rank2[b] <= rank1[b];
      end

      assign r2_word[b*LANE_W +: LANE_W] = rank2[b];

      assert_lane_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
         load_n[b] |=> $stable(rank2[b]));
   end

endmodule

// File: rtl/mbt_seq.sv
module mbt_seq import mbt_pkg::*; #(
   parameter int DATA_W        = 16,
   parameter int FAILSAFE_BITS = 768
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fall_next,
   input  logic       rise_next,
   input  logic       en_n,
   input  logic       sync_sel,
   output logic       send_data,
   output logic       word_start,
   output sync_kind_t word_sync,
   output logic       load_shift,
   output logic       abort,
   output logic       timeout
);
   localparam int WORD_PER = DATA_W + 4;
   localparam int PCW      = $clog2(WORD_PER);
   localparam int FCW      = $clog2(FAILSAFE_BITS + 1);
   localparam logic [PCW-1:0] P_LAST   = PCW'(WORD_PER - 1);
   localparam logic [PCW-1:0] P_SD_ON  = PCW'(2);
   localparam logic [PCW-1:0] P_SD_OFF = PCW'(DATA_W + 2);
   localparam logic [FCW-1:0] F_LAST   = FCW'(FAILSAFE_BITS - 1);

   seq_state_t     state;
   logic [PCW-1:0] pcnt;
   logic [FCW-1:0] msg_cnt;
   logic           cont;
   logic           running;

   assign running    = (state == SEQ_RUN);
   assign abort      = fall_next && running && (msg_cnt == F_LAST);
   assign load_shift = fall_next && running && (pcnt == P_SD_ON) && !abort;
   assign word_start = rise_next && running && (pcnt == '0);
   assign word_sync  = sync_sel ? SYNC_DATA : SYNC_CMD;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SEQ_IDLE;
         pcnt      <= '0;
         msg_cnt   <= '0;
         cont      <= 1'b0;
         send_data <= 1'b0;
         timeout   <= 1'b0;
      end else if (abort) begin
         state     <= SEQ_IDLE;
         pcnt      <= '0;
         msg_cnt   <= '0;
         send_data <= 1'b0;
         timeout   <= 1'b1;
      end else begin
         if (en_n)
            timeout <= 1'b0;
         if (rise_next && running && pcnt == P_LAST)
            cont <= !en_n;
         if (fall_next) begin
            if (!running) begin
               pcnt    <= '0;
               msg_cnt <= '0;
               if (!en_n && !timeout) begin
                  state <= SEQ_RUN;
                  cont  <= 1'b0;
               end
            end else begin
               msg_cnt <= msg_cnt + 1'b1;
               if (pcnt == P_SD_ON)
                  send_data <= 1'b1;
               if (pcnt == P_SD_OFF)
                  send_data <= 1'b0;
               if (pcnt == P_LAST) begin
                  pcnt <= '0;
                  if (!cont) begin
                     state   <= SEQ_IDLE;
                     msg_cnt <= '0;
                  end
               end else begin
                  pcnt <= pcnt + 1'b1;
               end
            end
         end
      end
   end

   assert_fs_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (msg_cnt <= F_LAST));

   assert_sd_in_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
      send_data |-> running);

endmodule

// File: rtl/mbt_enc.sv
module mbt_enc import mbt_pkg::*; #(
   parameter int DATA_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              half_next,
   input  logic              word_start,
   input  sync_kind_t        word_sync,
   input  logic              load_shift,
   input  logic [DATA_W-1:0] r2_word,
   input  logic              abort,
   output logic              tx_pos,
   output logic              tx_neg
);
   localparam int WORD_HALVES = SYNC_HALVES + 2 * DATA_W + 2;
   localparam int HW = $clog2(WORD_HALVES);
   localparam logic [HW-1:0] H_SYNC_END = HW'(SYNC_HALVES);
   localparam logic [HW-1:0] H_DATA_END = HW'(SYNC_HALVES + 2 * DATA_W);
   localparam logic [HW-1:0] H_LAST     = HW'(WORD_HALVES - 1);
   localparam logic [HW-1:0] H_SH_LO    = HW'(SYNC_HALVES + 1);
   localparam logic [HW-1:0] H_SH_HI    = HW'(SYNC_HALVES + 2 * DATA_W - 3);

   logic              busy;
   logic [HW-1:0]     hidx;
   sync_kind_t        kind;
   logic [DATA_W-1:0] shreg;
   logic              par_bit;
   logic              cell_val;
   logic              lvl;
   logic              do_shift;

   assign do_shift = half_next && busy && hidx[0] &&
                     (hidx >= H_SH_LO) && (hidx <= H_SH_HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         hidx <= '0;
         kind <= SYNC_CMD;
      end else if (abort) begin
         busy <= 1'b0;
         hidx <= '0;
      end else if (word_start) begin
         busy <= 1'b1;
         hidx <= '0;
         kind <= word_sync;
      end else if (half_next && busy) begin
         if (hidx == H_LAST) begin
            busy <= 1'b0;
            hidx <= '0;
         end else begin
            hidx <= hidx + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg   <= '0;
         par_bit <= 1'b0;
      end else if (load_shift) begin
         shreg   <= r2_word;
         par_bit <= ~^r2_word;
      end else if (do_shift) begin
         shreg   <= {shreg[DATA_W-2:0], 1'b0};
      end
   end

   always_comb begin
      cell_val = par_bit;
      if (hidx < H_DATA_END)
         cell_val = shreg[DATA_W-1];
      if (hidx < H_SYNC_END)
         lvl = sync_level(kind, int'(hidx));
      else
         lvl = hidx[0] ? !cell_val : cell_val;
   end

   assign tx_pos = busy && lvl;
   assign tx_neg = busy && !lvl;

endmodule

// File: rtl/mbus_word_tx.sv
module mbus_word_tx import mbt_pkg::*; #(
   parameter int DATA_W        = 16,
   parameter int HALF_CLKS     = 4,
   parameter int FAILSAFE_BITS = 768,
   localparam int LANES        = DATA_W / LANE_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en_n,
   input  logic              sync_sel,
   input  logic [DATA_W-1:0] par_in,
   input  logic              r1_open,
   input  logic [LANES-1:0]  load_n,
   output logic              tx_pos,
   output logic              tx_neg,
   output logic              send_data,
   output logic              bit_clk,
   output logic              fs_timeout
);
   if (DATA_W < LANE_W || (DATA_W % LANE_W) != 0) begin : g_bad_width
      $error("DATA_W must be a non-zero multiple of the lane width");
   end
   if (HALF_CLKS < 2) begin : g_bad_half
      $error("HALF_CLKS must be at least 2");
   end
   if (FAILSAFE_BITS <= DATA_W + 4) begin : g_bad_limit
      $error("FAILSAFE_BITS must exceed one word");
   end

   logic              fall_next;
   logic              rise_next;
   logic              word_start;
   sync_kind_t        word_sync;
   logic              load_shift;
   logic              abort;
   logic [DATA_W-1:0] r2_word;

   mbt_bitclk #(.HALF_CLKS(HALF_CLKS)) u_bitclk (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_clk   (bit_clk),
      .fall_next (fall_next),
      .rise_next (rise_next)
   );

   mbt_ranks #(.DATA_W(DATA_W)) u_ranks (
      .clk     (clk),
      .rst_n   (rst_n),
      .par_in  (par_in),
      .r1_open (r1_open),
      .load_n  (load_n),
      .r2_word (r2_word)
   );

   mbt_seq #(.DATA_W(DATA_W), .FAILSAFE_BITS(FAILSAFE_BITS)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .fall_next  (fall_next),
      .rise_next  (rise_next),
      .en_n       (tx_en_n),
      .sync_sel   (sync_sel),
      .send_data  (send_data),
      .word_start (word_start),
      .word_sync  (word_sync),
      .load_shift (load_shift),
      .abort      (abort),
      .timeout    (fs_timeout)
   );

   mbt_enc #(.DATA_W(DATA_W)) u_enc (
      .clk        (clk),
      .rst_n      (rst_n),
      .half_next  (fall_next || rise_next),
      .word_start (word_start),
      .word_sync  (word_sync),
      .load_shift (load_shift),
      .r2_word    (r2_word),
      .abort      (abort),
      .tx_pos     (tx_pos),
      .tx_neg     (tx_neg)
   );

   assert_legs_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_pos && tx_neg));

   assert_null_on_fs_R11: assert property (@(posedge clk) disable iff (!rst_n)
      fs_timeout |-> (!tx_pos && !tx_neg && !send_data));

   assert_sd_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(send_data) |-> (!bit_clk && $past(bit_clk)));

   assert_post_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!tx_pos && !tx_neg && !send_data));

endmodule

// File: tb/mbus_word_tx_tb.sv
module mbus_word_tx_tb;
   localparam int DW = 16;
   localparam int HC = 4;
   localparam int LN = DW / 8;
   localparam int WH = 6 + 2 * DW + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tx_en_n = 1'b1;
   logic          sync_sel = 1'b0;
   logic          r1_open = 1'b0;
   logic [DW-1:0] par_in = '0;
   logic [LN-1:0] load_n = '1;
   logic          tx_pos, tx_neg, send_data, bit_clk, fs_timeout;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   bit mon_off = 1'b0;
   bit done = 1'b0;

   typedef struct {
      logic  lvl;
      string tag;
   } exp_t;
   exp_t exp_q[$];

   logic [DW-1:0] msg_w [8];
   logic          msg_k [8];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   mbus_word_tx u_dut (
      .clk(clk), .rst_n(rst_n), .tx_en_n(tx_en_n), .sync_sel(sync_sel),
      .par_in(par_in), .r1_open(r1_open), .load_n(load_n),
      .tx_pos(tx_pos), .tx_neg(tx_neg), .send_data(send_data),
      .bit_clk(bit_clk), .fs_timeout(fs_timeout)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
      end
   endtask

   function automatic logic exp_half(input logic [DW-1:0] w, input logic dsync, input int h);
      logic b;
      if (h < 6) return dsync ? (h >= 3) : (h < 3);
      if (h < 6 + 2 * DW) b = w[DW - 1 - (h - 6) / 2];
      else b = ~^w;
      return (h % 2 == 0) ? b : !b;
   endfunction

   task automatic push_word(input logic [DW-1:0] w, input logic dsync,
                            input int nh, input string tag);
      for (int h = 0; h < nh; h++) begin
         exp_t e;
         e.lvl = exp_half(w, dsync, h);
         e.tag = (h < 6) ? "R3" : (h < 6 + 2 * DW) ? "R4" : "R5";
         if (tag != "") e.tag = tag;
         exp_q.push_back(e);
      end
   endtask

   task automatic clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   // R9: par_in is scrambled right after the first rank closes
   task automatic load_word(input logic [DW-1:0] w, input logic [LN-1:0] lanes_n);
      @(negedge clk);
      par_in = w;
      r1_open = 1'b1;
      clks(2);
      r1_open = 1'b0;
      par_in = ~w;
      @(negedge clk);
      load_n = lanes_n;
      clks(2);
      load_n = '1;
   endtask

   // scoreboard monitor: one sample in the middle of every half bit
   initial begin : monitor
      int   cnt;
      logic pb;
      exp_t e;
      cnt = 0;
      pb = 1'b0;
      forever begin
         @(negedge clk);
         if (bit_clk !== pb) begin
            cnt = 0;
            pb = bit_clk;
         end else begin
            cnt++;
         end
         if (cnt == 1 && !mon_off && rst_n) begin
            if (tx_pos && tx_neg) begin
               chk(1'b0, "R6", "both legs high", 1, 0);
            end else if (tx_pos || tx_neg) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R8", "line active with nothing expected", 1, 0);
               end else begin
                  e = exp_q.pop_front();
                  chk(tx_pos === e.lvl && tx_neg === !e.lvl, e.tag,
                      "line half level (R6 legs complementary)", tx_pos, e.lvl);
               end
            end
         end
      end
   end

   task automatic wait_drain(input string tag);
      for (int k = 0; k < 5000 && exp_q.size() != 0; k++) @(negedge clk);
      clks(10 * HC);
      chk(exp_q.size() == 0, tag, "expected halves left unsent", exp_q.size(), 0);
      chk(!tx_pos && !tx_neg && !send_data, "R8", "line null after message",
          {tx_pos, tx_neg, send_data}, 0);
   endtask

   task automatic send_msg(input int n, input bit measure, input bit preload, input string tag);
      int t0, t1, t2;
      t0 = 0;
      if (preload) load_word(msg_w[0], '0);
      for (int i = 0; i < n; i++) push_word(msg_w[i], msg_k[i], WH, tag);
      @(negedge clk);
      sync_sel = msg_k[0];
      tx_en_n = 1'b0;
      if (measure) begin
         while (!(tx_pos || tx_neg)) @(negedge clk);
         t0 = cyc;
      end
      for (int i = 0; i < n; i++) begin
         while (!send_data) @(negedge clk);
         t1 = cyc;
         if (measure && i == 0)
            chk(t1 - t0 == 5 * HC, "R2", "clocks from sync start to send_data rise",
                t1 - t0, 5 * HC);
         if (i + 1 < n) begin
            sync_sel = msg_k[i + 1];
            load_word(msg_w[i + 1], '0);
         end
         while (send_data) @(negedge clk);
         t2 = cyc;
         chk(t2 - t1 == 32 * HC, "R2", "send_data high clocks", t2 - t1, 32 * HC);
         if (i + 1 == n) tx_en_n = 1'b1;
      end
      wait_drain("R7");
   endtask

   initial begin : main
      clks(5);
      chk(!tx_pos && !tx_neg && !send_data && !fs_timeout, "R1", "outputs in reset",
          {tx_pos, tx_neg, send_data, fs_timeout}, 0);
      rst_n = 1'b1;
      clks(20);
      chk(!tx_pos && !tx_neg && !send_data && !fs_timeout, "R1", "outputs idle after reset",
          {tx_pos, tx_neg, send_data, fs_timeout}, 0);

      // single words: R2 timing, R3 sync kinds, R4 bit order, R5 parity, R8 stop
      msg_w[0] = 16'hA5C3; msg_k[0] = 1'b0; send_msg(1, 1'b1, 1'b1, "");
      msg_w[0] = 16'h0000; msg_k[0] = 1'b1; send_msg(1, 1'b1, 1'b1, "");
      msg_w[0] = 16'hFFFF; msg_k[0] = 1'b0; send_msg(1, 1'b0, 1'b1, "");
      msg_w[0] = 16'h0001; msg_k[0] = 1'b1; send_msg(1, 1'b0, 1'b1, "");

      // R7: three back-to-back words, reloaded mid-message, mixed syncs
      msg_w[0] = 16'h8001; msg_k[0] = 1'b0;
      msg_w[1] = 16'h7FFE; msg_k[1] = 1'b1;
      msg_w[2] = 16'h3C3C; msg_k[2] = 1'b1;
      send_msg(3, 1'b0, 1'b1, "");

      // R10: only the low lane is loaded; the high lane keeps 8'h3C
      load_word(16'h1234, 2'b10);
      msg_w[0] = 16'h3C34; msg_k[0] = 1'b0;
      send_msg(1, 1'b0, 1'b0, "R10");

      // R9: the word sent is the one latched, not the scrambled input
      load_word(16'h9E17, 2'b00);
      msg_w[0] = 16'h9E17; msg_k[0] = 1'b1;
      send_msg(1, 1'b0, 1'b0, "R9");

      // R11: fail-safe cut at bit period 768, inside word 39 after 15 halves
      load_word(16'h5555, '0);
      sync_sel = 1'b1;
      for (int i = 0; i < 38; i++) push_word(16'h5555, 1'b1, WH, "R11");
      push_word(16'h5555, 1'b1, 15, "R11");
      @(negedge clk);
      tx_en_n = 1'b0;
      for (int k = 0; k < 20000 && !fs_timeout; k++) @(negedge clk);
      chk(fs_timeout, "R11", "timeout flag raised", fs_timeout, 1);
      chk(!tx_pos && !tx_neg && !send_data, "R11", "line null at cutoff",
          {tx_pos, tx_neg, send_data}, 0);
      clks(200);
      chk(!tx_pos && !tx_neg && !send_data && fs_timeout, "R11", "still stopped, enable held",
          {tx_pos, tx_neg, send_data, fs_timeout}, 1);
      chk(exp_q.size() == 0, "R11", "halves before cutoff", exp_q.size(), 0);
      tx_en_n = 1'b1;
      clks(3);
      chk(!fs_timeout, "R11", "timeout cleared by enable release", fs_timeout, 0);

      // R12: reset in the middle of a word
      mon_off = 1'b1;
      exp_q.delete();
      load_word(16'hBEEF, '0);
      @(negedge clk);
      tx_en_n = 1'b0;
      for (int k = 0; k < 2000 && !send_data; k++) @(negedge clk);
      clks(3);
      rst_n = 1'b0;
      clks(130);
      chk(!tx_pos && !tx_neg && !send_data, "R12", "null while in reset",
          {tx_pos, tx_neg, send_data}, 0);
      tx_en_n = 1'b1;
      rst_n = 1'b1;
      clks(2);
      chk(!tx_pos && !tx_neg && !send_data && !fs_timeout, "R12", "null after reset release",
          {tx_pos, tx_neg, send_data, fs_timeout}, 0);
      clks(40 * HC);
      chk(!tx_pos && !tx_neg && !send_data, "R12", "no resumption", {tx_pos, tx_neg, send_data}, 0);
      mon_off = 1'b0;

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule